// File: doc/BRIEF.md
# Buffered SPI Master

This block is a memory-mapped SPI master for a system bus. Software uses three registers. The control register sets the serial clock rate, clock polarity, clock phase, frame width, bit order, chip-select handling and the enable. The status register reports whether the transmit buffer is empty, whether a received word is waiting, and whether the engine is busy. The data register is the transmit buffer on writes and the receive buffer on reads.

A write to the data register fills a one-word transmit holding buffer. The shift engine takes that word as soon as it is free and allowed to run, so the buffer empties again at the start of the frame. Software can therefore queue the next word while the current one is still shifting, and frames follow each other with no idle clock periods between them.

Each completed frame is copied into a receive buffer and raises a flag. Reading the data register returns that word and clears the flag. Two optional interrupt lines follow the empty and full flags.

Top module: `spi_master_core`

## Requirements
- R1: The control field in bits [2:0] (RATE) sets the serial clock period to 2^(RATE+1) system clocks. Every serial clock level inside a frame lasts exactly 2^RATE clocks, so RATE=3 divides by 16 and RATE=7 divides by 256.
- R2: While no frame is shifting, SCK sits at the polarity bit (control bit 3). With phase bit 4 clear, data is sampled on the edge leaving the rest level, and the first bit is driven before that edge. With phase bit 4 set, data is driven on the edge leaving the rest level and sampled on the edge returning to it.
- R3: Control bit 5 selects 16-bit frames when set and 8-bit frames when clear. In 8-bit mode only data bits [7:0] are sent, and received words read back with bits [15:8] at zero.
- R4: Control bit 6 selects LSB-first order when set and MSB-first order when clear. The same order applies to MOSI and to MISO.
- R5: The register map is: address 0 control, address 1 status, address 2 data. Status bit 0 is TXE. A data write clears TXE. TXE returns to 1 in the cycle the shift engine takes the word in parallel, at the start of the frame.
- R6: At the end of a frame, the received word is placed in the receive buffer and status bit 1 (RXNE) is set. A read of address 2 returns that word and clears RXNE.
- R7: A word that is written while a frame is shifting is sent right after that frame. The spacing between the last SCK edge of one frame and the first SCK edge of the next is 2^RATE clocks, the same as inside a frame.
- R8: A frame may start only when all of these hold: enable (bit 10) is set, master (bit 9) is set, and slave select is high. With bit 7 set, slave select is the internal bit 8. With bit 7 clear, slave select is the input pin nss_in. Until then a buffered word stays pending and SCK stays at rest.
- R9: Status bit 2 (BSY) is high while a frame shifts or a word is pending. It falls after the last frame once the transmit buffer is empty.
- R10: irq_tx is high when TXE is 1 and control bit 11 is set. irq_rx is high when RXNE is 1 and control bit 12 is set.
- R11: A data write while the transmit buffer is full is ignored. The pending word is sent unchanged, no extra frame is produced, and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a data read clears RXNE) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| nss_in | input | 1 | External slave-select level, used when bit 7 is clear |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| irq_tx | output | 1 | Transmit-empty interrupt |
| irq_rx | output | 1 | Receive-full interrupt |

## Verification
The hardest case to reach is the frame boundary in a stream. The refill has to land inside a frame, and the last edge of one frame has to line up with the first edge of the next. The bench reaches it by polling TXE and writing the next word as soon as the engine takes the previous one. A serial-side monitor measures the spacing of every SCK edge across those boundaries.

An ignored write needs the buffer to stay full, which the running engine would prevent. The bench therefore clears the enable, writes twice, and only then enables the engine. It expects exactly one frame, carrying the first word.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W   = 16;
  localparam int NARROW_W = 8;
  localparam int RATE_W   = 3;
  localparam int CNT_W    = (1 << RATE_W);
  localparam int EDGE_W   = $clog2(2 * WORD_W);
  localparam int ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(2);

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic              rx_irq_en;
    logic              tx_irq_en;
    logic              enable;
    logic              master;
    logic              sel_int;
    logic              sel_soft;
    logic              lsb_first;
    logic              wide;
    logic              cpha;
    logic              cpol;
    logic [RATE_W-1:0] rate;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // clocks per SCK level
  function automatic logic [CNT_W-1:0] half_period(input logic [RATE_W-1:0] rate);
    return CNT_W'(1) << rate;
  endfunction

  // index of the final SCK edge in a frame
  function automatic logic [EDGE_W-1:0] final_edge(input logic wide);
    return wide ? EDGE_W'(2 * WORD_W - 1) : EDGE_W'(2 * NARROW_W - 1);
  endfunction

  function automatic word_t frame_mask(input logic wide);
    return wide ? '1 : word_t'((1 << NARROW_W) - 1);
  endfunction

  // bit that goes on the wire next
  function automatic logic head_bit(input word_t w, input logic wide, input logic lsb);
    if (lsb) return w[0];
    return wide ? w[WORD_W-1] : w[NARROW_W-1];
  endfunction

  function automatic word_t advance(input word_t w, input logic lsb);
    return lsb ? (w >> 1) : (w << 1);
  endfunction

  // place a sampled bit into the receive accumulator
  function automatic word_t insert_bit(input word_t acc, input logic b,
                                       input logic wide, input logic lsb);
    word_t r;
    if (!lsb) begin
      r = {acc[WORD_W-2:0], b};
    end else begin
      r = acc >> 1;
      if (wide) r[WORD_W-1] = b;
      else      r[NARROW_W-1] = b;
    end
    return r & frame_mask(wide);
  endfunction
endpackage

// File: rtl/spim_baud.sv
module spim_baud
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_val;

  assign top_val = half_period(rate) - CNT_W'(1);
  assign tick    = running && (cnt_q == top_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (!running || restart)   cnt_q <= '0;
    else if (cnt_q == top_val)      cnt_q <= '0;
    else                            cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl,
  input  logic  run,
  input  logic  tick,
  input  logic  tx_full,
  input  word_t tx_word,
  input  logic  miso,
  output logic  load_evt,
  output logic  frame_done,
  output word_t rx_word,
  output logic  shifting,
  output logic  sck,
  output logic  mosi
);
  logic              active_q;
  logic              sck_q;
  logic              mosi_q;
  word_t             tx_sh;
  word_t             rx_sh;
  word_t             rx_next;
  logic [EDGE_W-1:0] edge_q;
  logic              leading;
  logic              sample_now;
  logic              drive_now;

  assign leading    = ~edge_q[0];
  assign frame_done = tick && (edge_q == final_edge(ctrl.wide));
  assign sample_now = tick && (leading ^ ctrl.cpha);
  assign drive_now  = tick && !(leading ^ ctrl.cpha) && !frame_done;
  assign load_evt   = tx_full && run && (!active_q || frame_done);
  assign rx_next    = insert_bit(rx_sh, miso, ctrl.wide, ctrl.lsb_first);
  assign rx_word    = (ctrl.cpha ? rx_next : rx_sh) & frame_mask(ctrl.wide);

  assign shifting = active_q;
  assign sck      = active_q ? sck_q : ctrl.cpol;
  assign mosi     = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      edge_q   <= '0;
    end else if (load_evt) begin
      active_q <= 1'b1;
      sck_q    <= ctrl.cpol;
      edge_q   <= '0;
      rx_sh    <= '0;
      if (!ctrl.cpha) begin
        mosi_q <= head_bit(tx_word, ctrl.wide, ctrl.lsb_first);
        tx_sh  <= advance(tx_word, ctrl.lsb_first);
      end else begin
        tx_sh  <= tx_word;
      end
    end else if (frame_done) begin
      active_q <= 1'b0;
      sck_q    <= ctrl.cpol;
      edge_q   <= '0;
    end else if (tick) begin
      edge_q <= edge_q + EDGE_W'(1);
      sck_q  <= ~sck_q;
      if (sample_now) rx_sh <= rx_next;
      if (drive_now) begin
        mosi_q <= head_bit(tx_sh, ctrl.wide, ctrl.lsb_first);
        tx_sh  <= advance(tx_sh, ctrl.lsb_first);
      end
    end
  end
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  word_t             bus_wdata,
  input  logic              load_evt,
  input  logic              frame_done,
  input  word_t             rx_word,
  input  logic              busy,
  output ctrl_t             ctrl,
  output word_t             tx_word,
  output logic              tx_full,
  output logic              rxne,
  output logic              wr_data_evt,
  output word_t             bus_rdata
);
  logic  wr_ctrl;
  logic  rd_data;
  word_t rx_buf;

  assign wr_ctrl     = bus_sel && bus_wr && (bus_addr == A_CTRL);
  assign wr_data_evt = bus_sel && bus_wr && (bus_addr == A_DATA);
  assign rd_data     = bus_sel && bus_rd && (bus_addr == A_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_word <= '0;
      tx_full <= 1'b0;
    end else if (wr_data_evt && !tx_full) begin
      tx_word <= bus_wdata;
      tx_full <= 1'b1;
    end else if (load_evt) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf <= '0;
      rxne   <= 1'b0;
    end else if (frame_done) begin
      rx_buf <= rx_word;
      rxne   <= 1'b1;
    end else if (rd_data) begin
      rxne   <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = WORD_W'(ctrl);
      A_STAT:  bus_rdata = word_t'({busy, rxne, ~tx_full});
      A_DATA:  bus_rdata = rx_buf;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              nss_in,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              irq_tx,
  output logic              irq_rx
);
  ctrl_t ctrl;
  word_t tx_word;
  word_t rx_word;
  logic  tx_full;
  logic  rxne;
  logic  wr_data_evt;
  logic  load_evt;
  logic  frame_done;
  logic  shifting;
  logic  tick;
  logic  run;
  logic  busy;
  logic  sel_level;

  assign sel_level = ctrl.sel_soft ? ctrl.sel_int : nss_in;
  assign run       = ctrl.enable && ctrl.master && sel_level;
  assign busy      = shifting || tx_full;
  assign irq_tx    = ctrl.tx_irq_en && !tx_full;
  assign irq_rx    = ctrl.rx_irq_en && rxne;

  spim_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .load_evt    (load_evt),
    .frame_done  (frame_done),
    .rx_word     (rx_word),
    .busy        (busy),
    .ctrl        (ctrl),
    .tx_word     (tx_word),
    .tx_full     (tx_full),
    .rxne        (rxne),
    .wr_data_evt (wr_data_evt),
    .bus_rdata   (bus_rdata)
  );

  spim_baud u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (shifting),
    .restart (load_evt),
    .rate    (ctrl.rate),
    .tick    (tick)
  );

  spim_shift u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .run        (run),
    .tick       (tick),
    .tx_full    (tx_full),
    .tx_word    (tx_word),
    .miso       (miso),
    .load_evt   (load_evt),
    .frame_done (frame_done),
    .rx_word    (rx_word),
    .shifting   (shifting),
    .sck        (sck),
    .mosi       (mosi)
  );
endmodule

// File: rtl/spim_checker.sv
module spim_checker
  import spim_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sck,
  input logic              cpol,
  input logic              shifting,
  input logic              load_evt,
  input logic              tx_full,
  input logic              busy,
  input logic              rxne,
  input logic              wr_data_evt,
  input word_t             tx_word,
  input logic              frame_done,
  input logic              run,
  input logic              tick,
  input logic [RATE_W-1:0] rate
);
  logic [CNT_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      gap_q <= '0;
    else if (load_evt || tick)       gap_q <= '0;
    else if (shifting)               gap_q <= gap_q + CNT_W'(1);
  end

  a_r1_level_width: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == half_period(rate) - CNT_W'(1)));

  a_r2_rest_level: assert property (@(posedge clk) disable iff (!rst_n)
    !shifting |-> (sck == cpol));

  a_r5_load_frees_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !tx_full);

  a_r6_done_sets_rxne: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rxne);

  a_r8_no_start_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !load_evt);

  a_r9_busy_while_shifting: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |-> busy);

  a_r11_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_evt && tx_full && !load_evt) |=> (tx_full && $stable(tx_word)));
endmodule

bind spi_master_core spim_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sck         (sck),
  .cpol        (ctrl.cpol),
  .shifting    (shifting),
  .load_evt    (load_evt),
  .tx_full     (tx_full),
  .busy        (busy),
  .rxne        (rxne),
  .wr_data_evt (wr_data_evt),
  .tx_word     (tx_word),
  .frame_done  (frame_done),
  .run         (run),
  .tick        (tick),
  .rate        (ctrl.rate)
);

// File: tb/tb_spi_master_core.sv
`timescale 1ns/1ps
module tb_spi_master_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        nss_in = 1'b1;
  logic        miso_r = 1'b0;
  logic        sck, mosi, irq_tx, irq_rx;

  always #2.5 clk = ~clk;

  spi_master_core dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nss_in(nss_in), .miso(miso_r), .sck(sck), .mosi(mosi),
    .irq_tx(irq_tx), .irq_rx(irq_rx));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench view of the configuration
  int cfg_rate = 0;
  bit cfg_cpol = 0, cfg_cpha = 0, cfg_wide = 0, cfg_lsb = 0;
  bit mon_en = 0, stream_on = 0, burst_live = 0;

  logic [15:0] exp_mosi[$];
  logic [15:0] slave_q[$];
  logic [15:0] exp_rx[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0; bus_rd = 0;
  endtask

  // control layout: rate[2:0] cpol3 cpha4 wide5 lsb6 soft-sel7 int-sel8 master9 enable10 txie11 rxie12
  task automatic set_cfg(input int rate, input bit cpol, input bit cpha, input bit wide, input bit lsb,
                         input bit ssm = 1, input bit ssi = 1, input bit en = 1,
                         input bit txie = 0, input bit rxie = 0);
    logic [15:0] w;
    mon_en = 0;
    w = 16'(rate & 7) | (16'(cpol) << 3) | (16'(cpha) << 4) | (16'(wide) << 5) | (16'(lsb) << 6)
      | (16'(ssm) << 7) | (16'(ssi) << 8) | (16'(1) << 9) | (16'(en) << 10)
      | (16'(txie) << 11) | (16'(rxie) << 12);
    cfg_rate = rate; cfg_cpol = cpol; cfg_cpha = cpha; cfg_wide = wide; cfg_lsb = lsb;
    bus_write(2'd0, w);
    repeat (2) @(negedge clk);
    #1 mon_en = 1;
  endtask

  task automatic queue_frame(input logic [15:0] tx, input logic [15:0] rx);
    logic [15:0] m;
    m = cfg_wide ? 16'hFFFF : 16'h00FF;
    exp_mosi.push_back(tx & m);
    slave_q.push_back(rx & m);
    exp_rx.push_back(rx & m);
  endtask

  task automatic wait_flag(input int bitpos, input bit val, input string req);
    logic [15:0] s;
    for (int i = 0; i < 20000; i++) begin
      bus_read(2'd1, s);
      if (s[bitpos] == val) return;
    end
    chk(0, req, 32'(s[bitpos]), 32'(val));
  endtask

  task automatic take_rx(input string req);
    logic [15:0] d, e;
    bus_read(2'd2, d);
    e = (exp_rx.size() > 0) ? exp_rx.pop_front() : 16'hDEAD;
    chk(d === e, req, 32'(d), 32'(e));
  endtask

  task automatic one_frame(input logic [15:0] tx, input logic [15:0] rx, input string req);
    queue_frame(tx, rx);
    bus_write(2'd2, tx);
    wait_flag(1, 1'b1, req);
    take_rx(req);
    wait_flag(2, 1'b0, "R9 busy falls");
  endtask

  // serial-side monitor and slave model
  int          gap = 0, e_cnt = 0, k = 0;
  bit          have_word = 0;
  logic        prev_sck = 1'b0;
  logic [15:0] cur_slave = '0, acc = '0;

  always @(negedge clk) begin
    int  n;
    bit  lead;
    logic [15:0] e;
    n = cfg_wide ? 16 : 8;
    if (!mon_en || !rst_n) begin
      gap = 0;
    end else begin
      gap++;
      if (sck !== prev_sck) begin
        lead = (prev_sck == cfg_cpol);
        if (e_cnt != 0)
          chk(gap == (1 << cfg_rate), "R1 level width", 32'(gap), 32'(1 << cfg_rate));
        else if (burst_live)
          chk(gap == (1 << cfg_rate), "R7 gapless boundary", 32'(gap), 32'(1 << cfg_rate));
        gap = 0;
        if (lead ^ cfg_cpha) begin
          if (cfg_lsb) acc[k] = mosi; else acc[n-1-k] = mosi;
          k++;
        end
        e_cnt++;
        if (e_cnt == 2 * n) begin
          e = (exp_mosi.size() > 0) ? exp_mosi.pop_front() : 16'hBEEF;
          chk(acc === e, "R2/R3/R4 mosi frame", 32'(acc), 32'(e));
          e_cnt = 0; k = 0; acc = '0; have_word = 0;
          burst_live = stream_on;
        end
      end
    end
    if (!have_word && k == 0 && slave_q.size() > 0) begin
      cur_slave = slave_q.pop_front();
      have_word = 1;
    end
    if (have_word && k < n) miso_r = cfg_lsb ? cur_slave[k] : cur_slave[n-1-k];
    else miso_r = 1'b0;
    prev_sck = sck;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] s;
    logic [15:0] wlist[4];
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // reset state
    bus_read(2'd1, s);
    chk(s == 16'h0001, "R5/R9 reset status", 32'(s), 32'h1);
    chk(sck == 1'b0, "R2 reset sck", 32'(sck), 0);
    chk(irq_tx == 0 && irq_rx == 0, "R10 reset irq", 32'({irq_tx, irq_rx}), 0);

    // R5 TXE timing: cleared by write, set when engine takes word
    set_cfg(1, 0, 0, 0, 0);
    queue_frame(16'h00A5, 16'h003C);
    bus_write(2'd2, 16'h00A5);
    bus_read(2'd1, s);
    chk(s[0] == 0 && s[2] == 1, "R5 txe low after write", 32'(s), 32'h4);
    bus_read(2'd1, s);
    chk(s[0] == 1 && s[2] == 1, "R5 txe back at load", 32'(s), 32'h5);
    wait_flag(1, 1'b1, "R6 rxne");
    take_rx("R6 received byte");
    bus_read(2'd1, s);
    chk(s[1] == 0, "R6 rxne cleared by read", 32'(s), 0);

    // R2 the four clock modes
    for (int m = 0; m < 4; m++) begin
      set_cfg(1, m[1], m[0], 0, 0);
      chk(sck == m[1], "R2 rest level", 32'(sck), 32'(m[1]));
      one_frame(16'h0096 ^ 16'(m * 17), 16'h0069 + 16'(m), "R2 mode frame");
    end

    // R3/R4 widths, order, rates
    set_cfg(0, 0, 0, 1, 0);
    one_frame(16'hC3A1, 16'h5E17, "R3 16-bit msb");
    set_cfg(2, 1, 1, 0, 1);
    one_frame(16'hFF2D, 16'hAB81, "R4 8-bit lsb, upper bits zero R3");
    set_cfg(3, 0, 1, 1, 1);
    one_frame(16'h8E01, 16'h1F80, "R4 16-bit lsb");
    set_cfg(7, 1, 0, 0, 0);
    one_frame(16'h004B, 16'h00D2, "R1 divide by 256");

    // R7 back-to-back stream
    set_cfg(3, 0, 1, 0, 0);
    wlist = '{16'h0011, 16'h00E2, 16'h0073, 16'h00C4};
    stream_on = 1; burst_live = 0;
    for (int i = 0; i < 4; i++) queue_frame(wlist[i], 16'h00F0 - 16'(i * 9));
    for (int i = 0; i < 2; i++) begin
      wait_flag(0, 1'b1, "R7 txe");
      bus_write(2'd2, wlist[i]);
    end
    for (int i = 0; i < 4; i++) begin
      wait_flag(1, 1'b1, "R7 rxne");
      take_rx("R7 stream word");
      if (i + 2 < 4) begin
        wait_flag(0, 1'b1, "R7 txe");
        bus_write(2'd2, wlist[i+2]);
      end
    end
    wait_flag(2, 1'b0, "R9 busy falls after stream");
    stream_on = 0; burst_live = 0;

    // R11 write while full ignored
    set_cfg(2, 0, 0, 0, 0, 1, 1, 0);
    queue_frame(16'h005A, 16'h0033);
    bus_write(2'd2, 16'h005A);
    bus_write(2'd2, 16'h00FF);
    bus_read(2'd1, s);
    chk(s[0] == 0 && s[2] == 1, "R11/R9 pending word, busy", 32'(s), 32'h4);
    set_cfg(2, 0, 0, 0, 0, 1, 1, 1);
    wait_flag(1, 1'b1, "R11 rxne");
    take_rx("R11 first word kept");
    wait_flag(2, 1'b0, "R11 busy falls");
    repeat (80) @(negedge clk);
    chk(exp_mosi.size() == 0, "R11 no extra frame", 32'(exp_mosi.size()), 0);
    bus_read(2'd1, s);
    chk(s == 16'h0001, "R11 flags after", 32'(s), 32'h1);

    // R8 gating by internal select, then by pin
    set_cfg(1, 0, 0, 0, 0, 1, 0, 1);
    queue_frame(16'h0027, 16'h0048);
    bus_write(2'd2, 16'h0027);
    repeat (50) @(negedge clk);
    bus_read(2'd1, s);
    chk(s[0] == 0, "R8 held by internal select", 32'(s), 32'h4);
    chk(sck == 0, "R8 sck at rest", 32'(sck), 0);
    set_cfg(1, 0, 0, 0, 0, 1, 1, 1);
    wait_flag(1, 1'b1, "R8 rxne");
    take_rx("R8 released");
    wait_flag(2, 1'b0, "R8 busy falls");
    nss_in = 0;
    set_cfg(1, 0, 0, 0, 0, 0, 0, 1);
    queue_frame(16'h00B9, 16'h0066);
    bus_write(2'd2, 16'h00B9);
    repeat (50) @(negedge clk);
    bus_read(2'd1, s);
    chk(s[0] == 0, "R8 held by pin", 32'(s), 32'h4);
    nss_in = 1;
    wait_flag(1, 1'b1, "R8 rxne pin");
    take_rx("R8 pin released");
    wait_flag(2, 1'b0, "R8 busy falls");

    // R10 interrupts
    set_cfg(1, 0, 0, 0, 0, 1, 1, 1, 1, 1);
    chk(irq_tx == 1 && irq_rx == 0, "R10 tx irq idle", 32'({irq_tx, irq_rx}), 32'h2);
    queue_frame(16'h0042, 16'h0099);
    bus_write(2'd2, 16'h0042);
    wait_flag(1, 1'b1, "R10 rxne");
    #1 chk(irq_rx == 1, "R10 rx irq", 32'(irq_rx), 1);
    take_rx("R10 word");
    #1 chk(irq_rx == 0, "R10 rx irq clears", 32'(irq_rx), 0);
    set_cfg(1, 0, 0, 0, 0, 1, 1, 1, 0, 1);
    chk(irq_tx == 0, "R10 tx irq masked", 32'(irq_tx), 0);

    chk(exp_mosi.size() == 0 && exp_rx.size() == 0, "R6 scoreboard drained",
        32'(exp_mosi.size() + exp_rx.size()), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule